// File: doc/BRIEF.md
# Byte-Bus 16-bit Register Access Latch

This block sits between an 8-bit processor bus and a timer peripheral that holds four 16-bit registers: a counter, two compare values and a capture value. The bus can only move one byte per access, yet the peripheral must see each 16-bit value change in a single step. One temporary byte, shared by all four registers, bridges the two widths.

On a write, software sends the high byte first. That byte only goes into the temporary register. The low-byte write that follows hands the peripheral the full 16-bit word, formed from the temporary byte and the new low byte, together with a one-cycle strobe for the target register. The capture register is read-only from the bus.

On a read, software fetches the low byte first. That access returns the live low byte and, in the same clock cycle, copies the live high byte into the temporary register. A high-byte read that follows returns the stored copy, so the two halves belong to the same instant even if the peripheral has moved on. Every register offset and the byte width are parameters.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset the temporary byte is 0x00, all write strobes are low and wr_data is 0x0000. The temporary byte can be seen by reading any mapped high-byte address.
- R2: A write to a high-byte address (counter 0x2D, compare A 0x2B, compare B 0x29) stores the bus byte in the temporary register. It raises no write strobe.
- R3: A write to a low-byte address (counter 0x2C, compare A 0x2A, compare B 0x28) raises exactly one strobe, the one for that register, in the cycle after the write. The strobe lasts one cycle.
- R4: The word presented with a strobe is {temporary byte, written low byte}. A commit does not clear the temporary byte, so a later low write with no new high write reuses it.
- R5: Writes to the capture addresses (high 0x27, low 0x26) are ignored. They raise no strobe and leave the temporary byte unchanged.
- R6: A read of a low-byte address returns bits 7:0 of that register's live value. In the same cycle it loads bits 15:8 of that live value into the temporary register.
- R7: A read of any mapped high-byte address returns the temporary byte, not the live high byte.
- R8: The temporary byte is shared by all four registers. A high-byte write or a low-byte read to any register replaces what an earlier access to another register left there.
- R9: An access to an unmapped address returns 0x00 on a read. It raises no strobe and leaves the temporary byte unchanged.
- R10: While the read enable is low, bus_rdata is 0x00.
- R11: When write and read enables are both high in one cycle, the write takes effect and the read does not load the temporary register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 8 | Write byte |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| cnt_live | input | 16 | Live counter value from the peripheral |
| cmpa_live | input | 16 | Live compare A value |
| cmpb_live | input | 16 | Live compare B value |
| cap_live | input | 16 | Live capture value |
| bus_rdata | output | 8 | Read byte, valid in the cycle of the read |
| wr_data | output | 16 | Committed 16-bit word |
| wr_stb_cnt | output | 1 | Counter write strobe |
| wr_stb_cmpa | output | 1 | Compare A write strobe |
| wr_stb_cmpb | output | 1 | Compare B write strobe |

## Verification
The bench tests whether the temporary byte persists across a commit. A design that clears it would commit 0x00 as the upper half of the second word. It also changes the live counter between a low read and the high read that follows. A design that returns the live high byte would hand back a torn value. Writes to the capture pair and to unmapped addresses are followed by a high-byte read, which catches a design that lets them corrupt the shared byte or raise a strobe. A cycle with both enables high catches a design where the read load overrides the write commit.

// File: rtl/wrl_pkg.sv
package wrl_pkg;
   localparam int NUM_REGS = 4;
   localparam int NUM_WR   = 3;

   // Writable registers first; the read-only capture register is last.
   typedef enum logic [1:0] {
      REG_CNT  = 2'd0,
      REG_CMPA = 2'd1,
      REG_CMPB = 2'd2,
      REG_CAP  = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic     hit;
      logic     hi;
      reg_sel_e sel;
   } dec_t;
endpackage

// File: rtl/wrl_addr_decode.sv
module wrl_addr_decode
   import wrl_pkg::*;
#(
   parameter int                              ADDR_W = 6,
   parameter logic [NUM_REGS*ADDR_W-1:0]      LO_MAP = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);
   logic [NUM_REGS-1:0] lo_match;
   logic [NUM_REGS-1:0] hi_match;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_match
      localparam logic [ADDR_W-1:0] LO_A = LO_MAP[g*ADDR_W +: ADDR_W];
      localparam logic [ADDR_W-1:0] HI_A = LO_A | ADDR_W'(1);
      if (LO_A[0] != 1'b0) begin : g_bad_align
         $error("low-byte address of register %0d must be even", g);
      end
      assign lo_match[g] = (addr == LO_A);
      assign hi_match[g] = (addr == HI_A);
   end

   always_comb begin
      dec.hit = |(lo_match | hi_match);
      dec.hi  = |hi_match;
      dec.sel = REG_CNT;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (lo_match[i] || hi_match[i]) dec.sel = reg_sel_e'(i);
      end
   end
endmodule

// File: rtl/wrl_temp_latch.sv
module wrl_temp_latch #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stage_wr,
   input  logic [BYTE_W-1:0] wr_byte,
   input  logic              stage_rd,
   input  logic [BYTE_W-1:0] rd_byte,
   output logic [BYTE_W-1:0] temp_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         temp_q <= '0;
      end else if (stage_wr) begin
         temp_q <= wr_byte;
      end else if (stage_rd) begin
         temp_q <= rd_byte;
      end
   end
endmodule

// File: rtl/wrl_read_mux.sv
module wrl_read_mux
   import wrl_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int REG_W = 2 * BYTE_W
) (
   input  logic                      re,
   input  dec_t                      dec,
   input  logic [NUM_REGS*REG_W-1:0] live_bus,
   input  logic [BYTE_W-1:0]         temp_q,
   output logic [BYTE_W-1:0]         rdata,
   output logic [BYTE_W-1:0]         sel_hi_byte
);
   logic [REG_W-1:0] live_arr [NUM_REGS];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
      assign live_arr[g] = live_bus[g*REG_W +: REG_W];
   end

   assign sel_hi_byte = live_arr[dec.sel][REG_W-1:BYTE_W];

   always_comb begin
      rdata = '0;
      if (re && dec.hit) begin
         rdata = dec.hi ? temp_q : live_arr[dec.sel][BYTE_W-1:0];
      end
   end
endmodule

// File: rtl/wrl_commit.sv
module wrl_commit
   import wrl_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int REG_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  reg_sel_e          sel,
   input  logic [BYTE_W-1:0] lo_byte,
   input  logic [BYTE_W-1:0] temp_q,
   output logic [REG_W-1:0]  wr_data,
   output logic [NUM_WR-1:0] stb
);
   for (genvar g = 0; g < NUM_WR; g++) begin : g_stb
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stb[g] <= 1'b0;
         else        stb[g] <= commit && (sel == reg_sel_e'(g));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_data <= '0;
      end else if (commit) begin
         wr_data <= {temp_q, lo_byte};
      end
   end
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
   import wrl_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int BYTE_W   = 8,
   parameter int CNT_LO   = 'h2C,
   parameter int CMPA_LO  = 'h2A,
   parameter int CMPB_LO  = 'h28,
   parameter int CAP_LO   = 'h26,
   localparam int REG_W   = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [REG_W-1:0]  cnt_live,
   input  logic [REG_W-1:0]  cmpa_live,
   input  logic [REG_W-1:0]  cmpb_live,
   input  logic [REG_W-1:0]  cap_live,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic [REG_W-1:0]  wr_data,
   output logic              wr_stb_cnt,
   output logic              wr_stb_cmpa,
   output logic              wr_stb_cmpb
);
   localparam logic [NUM_REGS*ADDR_W-1:0] LO_MAP = {
      ADDR_W'(CAP_LO), ADDR_W'(CMPB_LO), ADDR_W'(CMPA_LO), ADDR_W'(CNT_LO)
   };

   if (BYTE_W < 1) begin : g_bad_byte
      $error("BYTE_W must be positive");
   end
   if (CNT_LO + 1 >= (1 << ADDR_W) || CMPA_LO + 1 >= (1 << ADDR_W) ||
       CMPB_LO + 1 >= (1 << ADDR_W) || CAP_LO + 1 >= (1 << ADDR_W)) begin : g_bad_addr
      $error("register addresses exceed ADDR_W");
   end

   dec_t              dec;
   logic [BYTE_W-1:0] temp_q;
   logic [BYTE_W-1:0] sel_hi_byte;
   logic [NUM_WR-1:0] stb_q;
   logic              writable;
   logic              stage_wr;
   logic              stage_rd;
   logic              commit;

   wrl_addr_decode #(.ADDR_W(ADDR_W), .LO_MAP(LO_MAP)) u_dec (
      .addr (bus_addr),
      .dec  (dec)
   );

   assign writable = dec.hit && (dec.sel != REG_CAP);
   assign stage_wr = bus_we && writable && dec.hi;
   assign commit   = bus_we && writable && !dec.hi;
   assign stage_rd = bus_re && !bus_we && dec.hit && !dec.hi;

   wrl_temp_latch #(.BYTE_W(BYTE_W)) u_temp (
      .clk      (clk),
      .rst_n    (rst_n),
      .stage_wr (stage_wr),
      .wr_byte  (bus_wdata),
      .stage_rd (stage_rd),
      .rd_byte  (sel_hi_byte),
      .temp_q   (temp_q)
   );

   wrl_read_mux #(.BYTE_W(BYTE_W)) u_rmux (
      .re          (bus_re),
      .dec         (dec),
      .live_bus    ({cap_live, cmpb_live, cmpa_live, cnt_live}),
      .temp_q      (temp_q),
      .rdata       (bus_rdata),
      .sel_hi_byte (sel_hi_byte)
   );

   wrl_commit #(.BYTE_W(BYTE_W)) u_commit (
      .clk     (clk),
      .rst_n   (rst_n),
      .commit  (commit),
      .sel     (dec.sel),
      .lo_byte (bus_wdata),
      .temp_q  (temp_q),
      .wr_data (wr_data),
      .stb     (stb_q)
   );

   assign wr_stb_cnt  = stb_q[REG_CNT];
   assign wr_stb_cmpa = stb_q[REG_CMPA];
   assign wr_stb_cmpb = stb_q[REG_CMPB];
endmodule

// File: rtl/wrl_checker.sv
module wrl_checker #(
   parameter int ADDR_W = 6,
   parameter int BYTE_W = 8,
   parameter int CNT_LO = 'h2C,
   parameter int CAP_LO = 'h26,
   localparam int REG_W = 2 * BYTE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [BYTE_W-1:0] bus_wdata,
   input logic              bus_we,
   input logic              bus_re,
   input logic [REG_W-1:0]  cnt_live,
   input logic [BYTE_W-1:0] bus_rdata,
   input logic [BYTE_W-1:0] temp_q,
   input logic [REG_W-1:0]  wr_data,
   input logic [2:0]        stb_q
);
   localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(CNT_LO);
   localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(CNT_LO + 1);
   localparam logic [ADDR_W-1:0] A_CAP_LO = ADDR_W'(CAP_LO);
   localparam logic [ADDR_W-1:0] A_CAP_HI = ADDR_W'(CAP_LO + 1);

   p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stb_q));

   p_cnt_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_CNT_LO) |=> (stb_q == 3'b001));

   p_strobe_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|stb_q) |-> $past(bus_we));

   p_commit_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|stb_q) |-> (wr_data == {$past(temp_q), $past(bus_wdata)}));

   p_hi_write_stage_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_CNT_HI) |=> (temp_q == $past(bus_wdata) && stb_q == 3'b000));

   p_cap_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (bus_addr == A_CAP_LO || bus_addr == A_CAP_HI))
      |=> ($stable(temp_q) && stb_q == 3'b000));

   p_low_read_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && !bus_we && bus_addr == A_CNT_LO) |=> (temp_q == $past(cnt_live[REG_W-1:BYTE_W])));

   p_hi_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && bus_addr == A_CNT_HI) |-> (bus_rdata == temp_q));

   p_rd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |-> (bus_rdata == '0));
endmodule

bind wide_reg_bridge wrl_checker #(
   .ADDR_W (ADDR_W),
   .BYTE_W (BYTE_W),
   .CNT_LO (CNT_LO),
   .CAP_LO (CAP_LO)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_we    (bus_we),
   .bus_re    (bus_re),
   .cnt_live  (cnt_live),
   .bus_rdata (bus_rdata),
   .temp_q    (temp_q),
   .wr_data   (wr_data),
   .stb_q     (stb_q)
);

// File: tb/wide_reg_bridge_bench.sv
module wide_reg_bridge_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [15:0] cnt_live = '0;
   logic [15:0] cmpa_live = '0;
   logic [15:0] cmpb_live = '0;
   logic [15:0] cap_live = '0;
   logic [7:0]  bus_rdata;
   logic [15:0] wr_data;
   logic        wr_stb_cnt, wr_stb_cmpa, wr_stb_cmpb;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   wide_reg_bridge u_wide_reg_bridge (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .cnt_live(cnt_live), .cmpa_live(cmpa_live),
      .cmpb_live(cmpb_live), .cap_live(cap_live), .bus_rdata(bus_rdata),
      .wr_data(wr_data), .wr_stb_cnt(wr_stb_cnt), .wr_stb_cmpa(wr_stb_cmpa),
      .wr_stb_cmpb(wr_stb_cmpb)
   );

   function automatic logic [2:0] stbs();
      return {wr_stb_cmpb, wr_stb_cmpa, wr_stb_cnt};
   endfunction

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // Write: drive at negedge, one edge, leave at next negedge with outputs settled.
   task automatic bus_wr(logic [5:0] a, logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_rd(logic [5:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      #2 d = bus_rdata;
      @(posedge clk);
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 strobes", 16'(stbs()), 16'h0);
      chk("R1 wr_data", wr_data, 16'h0000);
      chk("R10 idle rdata", 16'(bus_rdata), 16'h0);
      bus_rd(6'h2B, d);
      chk("R1 temp", 16'(d), 16'h00);
   endtask

   task automatic t_write_pair();
      bus_wr(6'h2B, 8'h12);
      chk("R2 no strobe on high", 16'(stbs()), 16'h0);
      bus_wr(6'h2A, 8'h34);
      chk("R3 cmpa strobe", 16'(stbs()), 16'b010);
      chk("R4 word", wr_data, 16'h1234);
      @(negedge clk);
      chk("R3 one cycle", 16'(stbs()), 16'h0);
   endtask

   task automatic t_reuse();
      bus_wr(6'h2C, 8'h56);
      chk("R3 cnt strobe", 16'(stbs()), 16'b001);
      chk("R4 reused temp", wr_data, 16'h1256);
      bus_wr(6'h29, 8'hA0);
      bus_wr(6'h28, 8'h0B);
      chk("R3 cmpb strobe", 16'(stbs()), 16'b100);
      chk("R4 cmpb word", wr_data, 16'hA00B);
   endtask

   task automatic t_cap_ignore();
      logic [7:0] d;
      bus_wr(6'h27, 8'hAA);
      chk("R5 cap high no strobe", 16'(stbs()), 16'h0);
      bus_wr(6'h26, 8'hBB);
      chk("R5 cap low no strobe", 16'(stbs()), 16'h0);
      chk("R5 wr_data held", wr_data, 16'hA00B);
      bus_rd(6'h2B, d);
      chk("R5 temp untouched", 16'(d), 16'hA0);
   endtask

   task automatic t_read_pair();
      logic [7:0] d;
      cnt_live = 16'hBEEF;
      bus_rd(6'h2C, d);
      chk("R6 live low", 16'(d), 16'hEF);
      cnt_live = 16'h0000;
      bus_rd(6'h2D, d);
      chk("R7 latched high", 16'(d), 16'hBE);
   endtask

   task automatic t_shared();
      logic [7:0] d;
      cmpa_live = 16'h7788;
      bus_rd(6'h2A, d);
      chk("R6 cmpa low", 16'(d), 16'h88);
      bus_wr(6'h29, 8'h99);
      bus_rd(6'h2B, d);
      chk("R8 overwritten by write", 16'(d), 16'h99);
      cap_live = 16'h4455;
      bus_rd(6'h26, d);
      chk("R6 cap low", 16'(d), 16'h55);
      bus_rd(6'h2D, d);
      chk("R8 overwritten by read", 16'(d), 16'h44);
   endtask

   task automatic t_unmapped();
      logic [7:0] d;
      bus_wr(6'h30, 8'h11);
      chk("R9 no strobe", 16'(stbs()), 16'h0);
      bus_rd(6'h30, d);
      chk("R9 read zero", 16'(d), 16'h00);
      bus_rd(6'h27, d);
      chk("R9 temp kept", 16'(d), 16'h44);
   endtask

   task automatic t_idle();
      @(negedge clk);
      bus_addr = 6'h2C; cnt_live = 16'h1357;
      #2 chk("R10 re low", 16'(bus_rdata), 16'h00);
   endtask

   task automatic t_both();
      logic [7:0] d;
      cmpa_live = 16'hC3D4;
      @(negedge clk);
      bus_addr = 6'h2A; bus_wdata = 8'h01; bus_we = 1'b1; bus_re = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0; bus_re = 1'b0;
      chk("R11 write commits", 16'(stbs()), 16'b010);
      chk("R11 word", wr_data, 16'h4401);
      bus_rd(6'h2B, d);
      chk("R11 no temp load", 16'(d), 16'h44);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_pair();
      t_reuse();
      t_cap_ignore();
      t_read_pair();
      t_shared();
      t_unmapped();
      t_idle();
      t_both();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule